// File: doc/BRIEF.md
# Serial Sequential-Read Streamer with Trailing Parity

This block runs the data phase of a sequential-read command. A controller gives it a start strobe and a word address. The block then reads a synchronous memory one word at a time, from that address up to the top of the array. Each word goes out on a single serial line, most significant bit first, one bit per rising clock edge. The stream stops early if chip select falls. When it does, the line is released at once and no completion is reported.

Two organisations are supported. In byte mode the block sends the low byte of every memory word, and the array ends at address 511. In word mode it sends all sixteen bits, high byte first, and the array ends at address 255. If parity was requested when the stream started, one extra bit follows the last data bit. That bit makes the number of ones in the whole packet even. The next memory read is issued ahead of time, so the output-enable stays high with no idle clock between words.

Top module: `seqrd_streamer`

## Requirements
- R1: While reset is held and after it is released with no start, `sdo_oe`, `sdo`, `done` and `mem_rd_en` are all 0.
- R2: A `start` sampled high while `cs` is high puts the first data bit on `sdo`, with `sdo_oe` high, after exactly two rising edges; in the cycle between, `sdo_oe` is 0. A `start` sampled while `cs` is low is ignored and issues no memory read.
- R3: Data bits leave MSB first, one per clock, from the start address and then each following address, with `sdo_oe` high continuously and no idle cycle between words.
- R4: With `org16`=0 at start, each word contributes only `mem_rd_data[7:0]` (8 bits), and the stream ends after address 511.
- R5: With `org16`=1 at start, each word contributes all 16 bits, bit 15 first, and the stream ends after address 255; `start_addr[8]` is ignored in this mode.
- R6: With `par_en`=1 at start, exactly one extra bit follows the last data bit. It equals the XOR of every data bit sent in the packet, so the packet carries an even number of ones.
- R7: With `par_en`=0 at start, no extra bit is sent, and `sdo_oe` falls right after the last data bit.
- R8: After a stream completes, `done` is high for exactly one cycle: the first cycle in which `sdo_oe` is low.
- R9: If `cs` is sampled low in any cycle, `sdo_oe` and `sdo` are 0 in the next cycle, and that stream never raises `done`.
- R10: Once a stream is running, changes on `start`, `par_en` and `org16` do not alter the bits sent or the stream length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a stream |
| start_addr | input | 9 | First word address of the stream |
| cs | input | 1 | Chip select level; low aborts the stream |
| par_en | input | 1 | Parity request, sampled with `start` |
| org16 | input | 1 | 1 = 16-bit words, 0 = byte mode; sampled with `start` |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 9 | Memory read address |
| mem_rd_data | input | 16 | Read data, valid one cycle after the request and held |
| sdo | output | 1 | Serial data out, 0 when not enabled |
| sdo_oe | output | 1 | Output enable; low means high impedance |
| done | output | 1 | One-cycle completion pulse |

## Verification
The stream is tried from several start addresses near the top of the array, in both organisations, with and without parity. Those runs separate the two bit-count-per-word cases, the two end addresses and the presence of the trailing bit. A word-mode run whose start address has bit 8 set shows that the address is folded into the lower half. A run aborted by chip select shows that the line is released at once and that no completion pulse appears. A run in which start, parity and organisation are toggled mid-stream shows that those inputs are ignored during a stream. A start given with chip select low shows that no read and no output follow.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_PAR   = 2'd3
    } srs_state_e;
endpackage

// File: rtl/srs_addr_ctr.sv
module srs_addr_ctr #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              inc,
    input  logic              wide,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              is_last
);
    localparam logic [ADDR_W-1:0] TOP_NARROW = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] TOP_WIDE   = {1'b0, {(ADDR_W-1){1'b1}}};

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = load_addr;
        end else if (inc) begin
            addr_d = addr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr      = addr_q;
    assign next_addr = addr_q + ADDR_W'(1);
    assign is_last   = (addr_q == (wide ? TOP_WIDE : TOP_NARROW));
endmodule

// File: rtl/srs_parity_acc.sv
module srs_parity_acc (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic bit_in,
    output logic par
);
    logic par_d, par_q;

    always_comb begin
        par_d = par_q;
        if (clr) begin
            par_d = 1'b0;
        end else if (step) begin
            par_d = par_q ^ bit_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= 1'b0;
        end else begin
            par_q <= par_d;
        end
    end

    assign par = par_q;
endmodule

// File: rtl/seqrd_streamer.sv
module seqrd_streamer #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              cs,
    input  logic              par_en,
    input  logic              org16,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              done
);
    import srs_pkg::*;

    localparam int BYTE_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BITS_WIDE   = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] BITS_NARROW = CNT_W'(BYTE_W);

    typedef struct packed {
        srs_state_e        state;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              pe;
        logic              wide;
        logic              done;
    } srs_regs_t;

    srs_regs_t r_d, r_q;

    logic [ADDR_W-1:0] cur_addr, nxt_addr, start_masked;
    logic              at_last, ag_load, ag_inc;
    logic              par_clr, par_step, par_bit;

    function automatic logic [DATA_W-1:0] frame_word(input logic w, input logic [DATA_W-1:0] d);
        return w ? d : {d[BYTE_W-1:0], {BYTE_W{1'b0}}};
    endfunction

    always_comb begin
        start_masked = start_addr;
        if (org16) begin
            start_masked[ADDR_W-1] = 1'b0;
        end
    end

    srs_addr_ctr #(.ADDR_W(ADDR_W)) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ag_load),
        .load_addr (start_masked),
        .inc       (ag_inc),
        .wide      (r_q.wide),
        .addr      (cur_addr),
        .next_addr (nxt_addr),
        .is_last   (at_last)
    );

    srs_parity_acc i_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (par_clr),
        .step   (par_step),
        .bit_in (r_q.sh[DATA_W-1]),
        .par    (par_bit)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        mem_rd_en   = 1'b0;
        mem_rd_addr = cur_addr;
        ag_load     = 1'b0;
        ag_inc      = 1'b0;
        par_clr     = 1'b0;
        par_step    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start && cs) begin
                    mem_rd_en   = 1'b1;
                    mem_rd_addr = start_masked;
                    ag_load     = 1'b1;
                    par_clr     = 1'b1;
                    r_d.pe      = par_en;
                    r_d.wide    = org16;
                    r_d.state   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (!cs) begin
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.sh    = frame_word(r_q.wide, mem_rd_data);
                    r_d.cnt   = r_q.wide ? BITS_WIDE : BITS_NARROW;
                    r_d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!cs) begin
                    r_d.state = ST_IDLE;
                end else begin
                    par_step = 1'b1;
                    r_d.sh   = r_q.sh << 1;
                    r_d.cnt  = r_q.cnt - CNT_W'(1);
                    if (r_q.cnt == CNT_W'(2) && !at_last) begin
                        mem_rd_en   = 1'b1;
                        mem_rd_addr = nxt_addr;
                    end
                    if (r_q.cnt == CNT_W'(1)) begin
                        if (!at_last) begin
                            ag_inc  = 1'b1;
                            r_d.sh  = frame_word(r_q.wide, mem_rd_data);
                            r_d.cnt = r_q.wide ? BITS_WIDE : BITS_NARROW;
                        end else if (r_q.pe) begin
                            r_d.state = ST_PAR;
                        end else begin
                            r_d.state = ST_IDLE;
                            r_d.done  = 1'b1;
                        end
                    end
                end
            end
            ST_PAR: begin
                r_d.state = ST_IDLE;
                r_d.done  = cs;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, sh: '0, cnt: '0, pe: 1'b0, wide: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo_oe = (r_q.state == ST_SHIFT) || (r_q.state == ST_PAR);
    assign sdo    = (r_q.state == ST_SHIFT) ? r_q.sh[DATA_W-1] :
                    (r_q.state == ST_PAR)   ? par_bit : 1'b0;
    assign done   = r_q.done;
endmodule

// File: rtl/srs_checker.sv
module srs_checker (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic sdo,
    input logic sdo_oe,
    input logic done,
    input logic mem_rd_en
);
    // R9: a low chip select releases the line and suppresses completion
    assert_cs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (!sdo_oe && !done));

    // R9: a released line carries no data
    assert_quiet_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    // R8: completion pulse is one cycle wide and only with the line released
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sdo_oe);

    // R2: output begins two cycles after the first read request
    assert_first_bit_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(mem_rd_en, 2));

    // R3: a prefetch during streaming is never followed by a gap
    assert_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && sdo_oe && cs) |=> sdo_oe);
endmodule

bind seqrd_streamer srs_checker i_srs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .done      (done),
    .mem_rd_en (mem_rd_en)
);

// File: tb/test_seqrd_streamer.sv
`timescale 1ns/1ps
module test_seqrd_streamer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [8:0]  start_addr = '0;
    logic        cs = 1'b1;
    logic        par_en = 1'b0;
    logic        org16 = 1'b0;
    logic        mem_rd_en;
    logic [8:0]  mem_rd_addr;
    logic [15:0] mem_rd_data;
    logic        sdo, sdo_oe, done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] mem [0:511];

    always #4 clk = ~clk;

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 16'((i * 40503) ^ 23130);
    end

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    end

    seqrd_streamer i_seqrd_streamer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .cs(cs), .par_en(par_en), .org16(org16),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_stream(input string req, input int sa, input bit wide,
                              input bit pe, input int abort_at, input bit poke);
        bit exp_q[$];
        bit got_q[$];
        int a, last, n, bad;
        logic [15:0] wd;
        bit p;
        a = wide ? (sa & 255) : sa;
        last = wide ? 255 : 511;
        p = 0;
        for (int w = a; w <= last; w++) begin
            wd = mem[w];
            if (!wide) wd = {wd[7:0], 8'h00};
            for (int b = 0; b < (wide ? 16 : 8); b++) begin
                exp_q.push_back(wd[15-b]);
                p ^= wd[15-b];
            end
        end
        if (pe) exp_q.push_back(p);

        @(negedge clk);
        start = 1'b1; start_addr = 9'(sa); org16 = wide; par_en = pe; cs = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(sdo_oe == 1'b0, "R2", "oe low in load cycle", sdo_oe, 0);
        if (poke) begin
            org16 = ~wide;
            par_en = ~pe;
        end
        n = 0;
        forever begin
            @(negedge clk);
            if (!sdo_oe) break;
            got_q.push_back(sdo);
            n++;
            if (poke) start = (n == 3);
            if (abort_at > 0 && n == abort_at) begin
                cs = 1'b0;
                @(negedge clk);
                check(sdo_oe == 1'b0 && sdo == 1'b0, "R9", "line released after cs low",
                      {sdo_oe, sdo}, 0);
                bad = 0;
                for (int k = 0; k < n; k++) if (got_q[k] != exp_q[k]) bad++;
                check(bad == 0, "R9", "bits before abort", bad, 0);
                bad = 0;
                for (int k = 0; k < 4; k++) begin
                    if (done) bad++;
                    if (k == 1) cs = 1'b1;
                    @(negedge clk);
                end
                check(bad == 0, "R9", "no done after abort", bad, 0);
                org16 = 1'b0; par_en = 1'b0;
                return;
            end
        end
        start = 1'b0;
        check(n > 0, "R2", "first bit two edges after start", n > 0, 1);
        check(n == exp_q.size(), req, "stream length", n, exp_q.size());
        bad = 0;
        for (int k = 0; k < n && k < exp_q.size(); k++) begin
            if (got_q[k] != exp_q[k]) begin
                if (bad == 0)
                    $display("FAIL %s bit %0d: actual=%0d expected=%0d", req, k, got_q[k], exp_q[k]);
                bad++;
            end
        end
        checks++;
        if (bad != 0) failures++;
        check(done == 1'b1, "R8", "done at first idle cycle", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R8", "done one cycle only", done, 0);
        org16 = 1'b0; par_en = 1'b0;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check(sdo_oe == 0 && sdo == 0 && done == 0, "R1", "outputs during reset",
              {sdo_oe, sdo, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sdo_oe == 0 && sdo == 0, "R1", "line idle after reset", {sdo_oe, sdo}, 0);
        check(done == 0, "R1", "done idle after reset", done, 0);
        check(mem_rd_en == 0, "R1", "no read after reset", mem_rd_en, 0);
    endtask

    task automatic test_start_cs_low();
        int bad;
        @(negedge clk);
        cs = 1'b0; start = 1'b1; start_addr = 9'd500;
        #1;
        check(mem_rd_en == 1'b0, "R2", "no read when cs low", mem_rd_en, 0);
        @(negedge clk);
        start = 1'b0;
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            if (sdo_oe || done) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R2", "start ignored with cs low", bad, 0);
        cs = 1'b1;
    endtask

    initial begin
        test_reset();
        run_stream("R3/R4/R7", 505, 1'b0, 1'b0, 0, 1'b0);
        run_stream("R4/R6", 508, 1'b0, 1'b1, 0, 1'b0);
        run_stream("R5/R6", 250, 1'b1, 1'b1, 0, 1'b0);
        run_stream("R5/R7", 9'h1FC, 1'b1, 1'b0, 0, 1'b0);
        run_stream("R3", 510, 1'b0, 1'b1, 0, 1'b0);
        run_stream("R9", 500, 1'b0, 1'b1, 11, 1'b0);
        run_stream("R10", 251, 1'b1, 1'b0, 0, 1'b1);
        test_start_cs_low();
        run_stream("R3/R4", 0, 1'b0, 1'b1, 0, 1'b0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule